// File: doc/BRIEF.md
# PWM Event-Trigger Prescaler

This block sits between a PWM timer's event-select logic and the consumers of its trigger outputs. It counts qualifying event strobes on several independent channels and, after a programmable number of them, emits a one-cycle pulse. The lower channels start analog-to-digital conversions. The highest-numbered channel raises an interrupt. Each channel exposes its running event count and a sticky status flag that software clears with a strobe.

The channels share one counting rule. The period select gives the number of events per pulse, and zero switches the channel off. A pulse clears the count and sets the flag. The channels differ only in what blocks a pulse. A conversion channel needs only its enable bit. The interrupt channel also needs its flag to be clear. While a channel is blocked, its counter climbs to the period and waits there, so the pulse comes on the first event after the block is lifted.

Top module: `etp_prescaler`

## Requirements
- R1: A channel's count output shows how many qualifying events have arrived since the count was last cleared, with values 0 up to 2^CW-1.
- R2: With period select p in 1..3 and the channel free to fire, the p-th event produces a pulse on `pulse_o` one cycle after the event strobe. The pulse lasts exactly one cycle.
- R3: With period select 0, the channel's count stays 0, events are ignored and no pulse is produced.
- R4: A conversion channel (index below NUM_CONV) pulses only while its enable bit is 1. While disabled, its count climbs to the period and holds there.
- R5: A conversion channel still pulses when its status flag is already set.
- R6: The count returns to 0 in the same clock edge that issues the pulse.
- R7: The interrupt channel (index NUM_CONV, here 2) does not pulse while it is disabled or its flag is set. Its count stops at the period value instead of wrapping.
- R8: When the interrupt channel is re-enabled, or its flag is cleared, while its count sits at the period, no pulse is issued until the next event. That event issues it.
- R9: A pulse sets the channel's flag on the same edge. A clear strobe resets the flag, but a pulse in the same cycle as a clear leaves the flag set.
- R10: Changing the period select does not alter the count. If the count already reaches the new period, the next event produces a pulse.
- R11: After reset, all counts, flags and pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NCH | Single-cycle qualifying event strobe per channel |
| en_i | input | NCH | Per-channel pulse enable |
| period_i | input | NCH x CW | Per-channel period select, 0 turns the channel off |
| flag_clr_i | input | NCH | Per-channel status flag clear strobe |
| pulse_o | output | NCH | Registered one-cycle trigger pulse per channel |
| count_o | output | NCH x CW | Per-channel event count |
| flag_o | output | NCH | Per-channel sticky status flag |

## Verification
The counting rule is run with period selects 1, 2 and 3 on a conversion channel, which shows whether the terminal compare is off by one. Period 0 is run with a burst of events to show that the channel is truly idle. The two blocking rules are separated by the same stimulus: events with the flag already set fire a conversion channel but stall the interrupt channel at its period. Releasing that stall by a flag clear and by a re-enable, and shrinking the period under a held count, show whether the release fires at once or waits for an event. A clear that coincides with a pulse decides the flag priority.

// File: rtl/etp_pkg.sv
package etp_pkg;

  // What may block a channel from firing once its period is reached.
  typedef enum logic {
    GATE_EN      = 1'b0,  // enable bit only (conversion triggers)
    GATE_EN_FLAG = 1'b1   // enable bit and pending flag (interrupt)
  } gate_policy_e;

endpackage

// File: rtl/etp_flag.sv
module etp_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  always_ff @(posedge clk) begin
    if (rst) flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // R9: a coincident set beats the clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    (set_i && clr_i) |=> flag_o);

  a_r9_clear_alone: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag_o);

endmodule

// File: rtl/etp_counter.sv
module etp_counter
  import etp_pkg::*;
#(
  parameter int           CW     = 2,
  parameter gate_policy_e POLICY = GATE_EN
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          evt_i,
  input  logic          en_i,
  input  logic          flag_i,
  input  logic [CW-1:0] period_i,
  output logic          fire_o,
  output logic          pulse_o,
  output logic [CW-1:0] count_o
);

  localparam logic [CW:0] ONE = {{CW{1'b0}}, 1'b1};

  logic          active;
  logic          reached;
  logic          allow;
  logic [CW:0]   count_inc;

  assign active    = (period_i != '0);
  assign count_inc = {1'b0, count_o} + ONE;
  assign reached   = active && (count_inc >= {1'b0, period_i});

  generate
    if (POLICY == GATE_EN_FLAG) begin : g_gate_flag
      assign allow = en_i && !flag_i;
    end else begin : g_gate_en
      assign allow = en_i;
    end
  endgenerate

  assign fire_o = evt_i && reached && allow;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_o <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= fire_o;
      if (!active) begin
        count_o <= '0;
      end else if (evt_i) begin
        if (fire_o) count_o <= '0;
        else if (count_o < period_i) count_o <= count_inc[CW-1:0];
      end
    end
  end

  // R6: a pulse leaves the counter at zero
  a_r6_cleared_on_pulse: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> (count_o == '0));

  // R3: period 0 keeps the count at zero and blocks pulses
  a_r3_idle_count: assert property (@(posedge clk) disable iff (rst)
    (period_i == '0) |=> (count_o == '0));
  a_r3_no_pulse_idle: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> $past(period_i != '0));

  // R4: a pulse needs an event and the enable bit
  a_r4_pulse_needs_enable: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> $past(evt_i && en_i));

  // R7: a blocked channel holds at or above its period
  a_r7_hold_at_period: assert property (@(posedge clk) disable iff (rst)
    (active && !allow && (count_o >= period_i)) |=> (count_o == $past(count_o)));

  generate
    if (POLICY == GATE_EN_FLAG) begin : g_flag_chk
      // R7: the interrupt channel never fires over a pending flag
      a_r7_no_fire_pending: assert property (@(posedge clk) disable iff (rst)
        pulse_o |-> $past(!flag_i));
    end
  endgenerate

endmodule

// File: rtl/etp_prescaler.sv
module etp_prescaler
  import etp_pkg::*;
#(
  parameter  int NUM_CONV = 2,
  parameter  int CW       = 2,
  localparam int NCH      = NUM_CONV + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NCH-1:0]          evt_i,
  input  logic [NCH-1:0]          en_i,
  input  logic [NCH-1:0][CW-1:0]  period_i,
  input  logic [NCH-1:0]          flag_clr_i,
  output logic [NCH-1:0]          pulse_o,
  output logic [NCH-1:0][CW-1:0]  count_o,
  output logic [NCH-1:0]          flag_o
);

  logic [NCH-1:0] fire;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam gate_policy_e POL = (c == NUM_CONV) ? GATE_EN_FLAG : GATE_EN;

    etp_counter #(.CW(CW), .POLICY(POL)) i_cnt (
      .clk      (clk),
      .rst      (rst),
      .evt_i    (evt_i[c]),
      .en_i     (en_i[c]),
      .flag_i   (flag_o[c]),
      .period_i (period_i[c]),
      .fire_o   (fire[c]),
      .pulse_o  (pulse_o[c]),
      .count_o  (count_o[c])
    );

    etp_flag i_flag (
      .clk    (clk),
      .rst    (rst),
      .set_i  (fire[c]),
      .clr_i  (flag_clr_i[c]),
      .flag_o (flag_o[c])
    );

    // R9: a pulse is always seen together with its flag
    a_r9_pulse_sets_flag: assert property (@(posedge clk) disable iff (rst)
      pulse_o[c] |-> flag_o[c]);
  end

endmodule

// File: tb/test_etp_prescaler.sv
module test_etp_prescaler;

  localparam int CW = 2;
  localparam int NCH = 3;
  localparam int A = 0, B = 1, I = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0]         evt = '0;
  logic [NCH-1:0]         en = '0;
  logic [NCH-1:0][CW-1:0] period = '0;
  logic [NCH-1:0]         clr = '0;
  logic [NCH-1:0]         pulse;
  logic [NCH-1:0][CW-1:0] count;
  logic [NCH-1:0]         flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  etp_prescaler #(.NUM_CONV(2), .CW(CW)) i_etp_prescaler (
    .clk(clk), .rst(rst), .evt_i(evt), .en_i(en), .period_i(period),
    .flag_clr_i(clr), .pulse_o(pulse), .count_o(count), .flag_o(flag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive one cycle of stimulus, sample after the capturing edge
  task automatic tick(input logic [NCH-1:0] m);
    evt = m;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic clear_flag(input int ch);
    clr[ch] = 1'b1;
    @(negedge clk);
    clr = '0;
  endtask

  task automatic t_reset;
    chk("R11 count A", count[A], 0);
    chk("R11 count INT", count[I], 0);
    chk("R11 flags", flag, 0);
    chk("R11 pulses", pulse, 0);
  endtask

  task automatic t_periods;
    en[A] = 1'b1;
    for (int p = 1; p <= 3; p++) begin
      period[A] = CW'(p);
      clear_flag(A);
      for (int k = 1; k <= p; k++) begin
        tick(3'b001);
        if (k < p) begin
          chk($sformatf("R1 count p=%0d k=%0d", p, k), count[A], k);
          chk($sformatf("R2 early pulse p=%0d", p), pulse[A], 0);
        end else begin
          chk($sformatf("R2 pulse p=%0d", p), pulse[A], 1);
          chk($sformatf("R6 count cleared p=%0d", p), count[A], 0);
          chk($sformatf("R9 flag set p=%0d", p), flag[A], 1);
        end
      end
      @(negedge clk);
      chk($sformatf("R2 one cycle p=%0d", p), pulse[A], 0);
    end
  endtask

  task automatic t_period0;
    en[B] = 1'b1;
    period[B] = '0;
    for (int k = 0; k < 5; k++) begin
      tick(3'b010);
      chk("R3 count stays 0", count[B], 0);
      chk("R3 no pulse", pulse[B], 0);
    end
  endtask

  task automatic t_conv_disable;
    clear_flag(A);
    en[A] = 1'b0;
    period[A] = 2'd2;
    tick(3'b001); chk("R4 disabled count 1", count[A], 1);
    tick(3'b001); chk("R4 disabled count 2", count[A], 2);
    tick(3'b001); chk("R4 disabled hold", count[A], 2);
    chk("R4 disabled no pulse", pulse[A], 0);
    en[A] = 1'b1;
    tick(3'b001);
    chk("R4 enabled pulse", pulse[A], 1);
    chk("R4 enabled count 0", count[A], 0);
  endtask

  task automatic t_conv_flag;
    period[A] = 2'd1;
    chk("R5 flag pending", flag[A], 1);
    tick(3'b001);
    chk("R5 pulse despite flag", pulse[A], 1);
  endtask

  task automatic t_int_stall;
    en[I] = 1'b1;
    period[I] = 2'd2;
    tick(3'b100); tick(3'b100);
    chk("R2 int pulse", pulse[I], 1);
    chk("R9 int flag", flag[I], 1);
    tick(3'b100); chk("R7 flag count 1", count[I], 1);
    tick(3'b100); chk("R7 flag count 2", count[I], 2);
    tick(3'b100);
    chk("R7 flag hold", count[I], 2);
    chk("R7 flag no pulse", pulse[I], 0);
    clear_flag(I);
    chk("R8 clr no pulse", pulse[I], 0);
    chk("R8 clr count held", count[I], 2);
    tick(3'b100);
    chk("R8 pulse after clr", pulse[I], 1);
    chk("R6 int count 0", count[I], 0);
    clear_flag(I);
    en[I] = 1'b0;
    tick(3'b100); tick(3'b100); tick(3'b100);
    chk("R7 disabled hold", count[I], 2);
    chk("R7 disabled no pulse", pulse[I], 0);
    en[I] = 1'b1;
    @(negedge clk);
    chk("R8 re-enable no pulse", pulse[I], 0);
    tick(3'b100);
    chk("R8 pulse after re-enable", pulse[I], 1);
  endtask

  task automatic t_flag_prio;
    chk("R9 flag A set", flag[A], 1);
    clr[A] = 1'b1;
    tick(3'b001);
    clr = '0;
    chk("R9 set wins pulse", pulse[A], 1);
    chk("R9 set wins flag", flag[A], 1);
    clear_flag(A);
    chk("R9 clear", flag[A], 0);
  endtask

  task automatic t_shrink;
    period[A] = 2'd3;
    tick(3'b001); tick(3'b001);
    chk("R10 count before", count[A], 2);
    period[A] = 2'd1;
    @(negedge clk);
    chk("R10 count kept", count[A], 2);
    chk("R10 no spontaneous pulse", pulse[A], 0);
    tick(3'b001);
    chk("R10 pulse", pulse[A], 1);
    chk("R10 count cleared", count[A], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_periods();
    t_period0();
    t_conv_disable();
    t_conv_flag();
    t_int_stall();
    t_flag_prio();
    t_shrink();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule